// File: doc/BRIEF.md
# Banked Peripheral Clock Enable Controller

This block holds one clock-enable bit for each of up to 64 peripherals and drives them out as a vector. Elsewhere on the chip, clock gating cells consume that vector. Software never writes the enable bits directly. It sets bits through a write-one-to-set register and clears them through a write-one-to-clear register. Because bits written as zero are ignored, independent drivers can change their own peripherals without a read-modify-write.

The peripherals are split into banks of 32. Each bank has its own set, clear and status registers. A peripheral's bit within its bank is its identifier modulo 32. The lowest identifiers (two by default) are always on: nothing can turn them off, and their status reads as one. Access is through a simple synchronous register bus with address, write strobe, write data, read strobe and read data. Read data is registered and appears one cycle after the read strobe.

Top module: `pcg_ctrl`

## Requirements
- R1: After reset, every clock enable is low except those of identifiers 0 and 1, which are high.
- R2: Identifiers 0 and 1 always read 1 in clk_en and in bank 0 status, whatever is written to set or clear.
- R3: Writing a 1 to bit k of the set register enables identifier 32*b+k from the next cycle. The set register is at 0x00 for bank 0 (b=0) and 0x10 for bank 1 (b=1).
- R4: Writing a 1 to bit k of the clear register disables identifier 32*b+k from the next cycle. The clear register is at 0x04 for bank 0 and 0x14 for bank 1.
- R5: Bits written as 0 to a set or clear register leave the corresponding enables unchanged.
- R6: A read of status (0x08 for bank 0, 0x18 for bank 1) returns that bank's current enable bits on bus_rdata in the cycle after bus_rd. Bit k of the result belongs to identifier 32*b+k.
- R7: Reads of set or clear registers, and reads of unmapped addresses, return 0.
- R8: Writes to a status register, to an unmapped address, or to an offset that is not one of 0x0/0x4/0x8 within a bank change no enable.
- R9: A write to one bank leaves the other bank's enables unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address of register |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| clk_en | output | 64 | One clock enable per peripheral identifier |

## Verification
The bench builds the block with its defaults: 64 peripherals, two fixed-on identifiers and an 8-bit address. With these values both banks exist, so bank isolation and the second bank's top bit (identifier 63) can be tested. A mirror model is updated on each write. Every status read is queued with the value the mirror predicts, and a monitor compares that value with bus_rdata one cycle later. The unmapped, misaligned and status-write cases test the decoder's rejection paths.

// File: rtl/pcg_pkg.sv
package pcg_pkg;

   localparam int unsigned PCG_BANK_W  = 32;
   localparam int unsigned PCG_MAX_IDS = 64;

   localparam logic [3:0] PCG_OFS_SET  = 4'h0;
   localparam logic [3:0] PCG_OFS_CLR  = 4'h4;
   localparam logic [3:0] PCG_OFS_STAT = 4'h8;

   typedef enum logic [1:0] {
      REG_NONE = 2'd0,
      REG_SET  = 2'd1,
      REG_CLR  = 2'd2,
      REG_STAT = 2'd3
   } pcg_reg_e;

endpackage

// File: rtl/pcg_decode.sv
module pcg_decode
   import pcg_pkg::*;
#(
   parameter int unsigned ADDR_W     = 8,
   parameter int unsigned NUM_BANKS  = 2,
   parameter int unsigned BANK_SEL_W = 1
) (
   input  logic [ADDR_W-1:0]     addr,
   output pcg_reg_e              kind,
   output logic [BANK_SEL_W-1:0] bank_sel
);

   localparam int unsigned HI_W = ADDR_W - 4;
   localparam logic [HI_W-1:0] BANK_LIM = HI_W'(NUM_BANKS);

   logic [HI_W-1:0] hi;
   assign hi = addr[ADDR_W-1:4];

   always_comb begin
      kind     = REG_NONE;
      bank_sel = hi[BANK_SEL_W-1:0];
      if (hi < BANK_LIM) begin
         unique case (addr[3:0])
            PCG_OFS_SET:  kind = REG_SET;
            PCG_OFS_CLR:  kind = REG_CLR;
            PCG_OFS_STAT: kind = REG_STAT;
            default:      kind = REG_NONE;
         endcase
      end
   end

endmodule

// File: rtl/pcg_bank.sv
module pcg_bank #(
   parameter int unsigned BANK_IDX   = 0,
   parameter int unsigned BANK_W     = 32,
   parameter int unsigned NUM_PERIPH = 64,
   parameter int unsigned NUM_FIXED  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BANK_W-1:0] set_mask,
   input  logic [BANK_W-1:0] clr_mask,
   output logic [BANK_W-1:0] en_bits
);

   localparam int unsigned FIRST_ID = BANK_IDX * BANK_W;

   for (genvar i = 0; i < BANK_W; i++) begin : g_bit
      localparam int unsigned ID = FIRST_ID + i;
      if (ID < NUM_FIXED) begin : g_fixed
         assign en_bits[i] = 1'b1;
      end else if (ID >= NUM_PERIPH) begin : g_absent
         assign en_bits[i] = 1'b0;
      end else begin : g_live
         logic q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)           q <= 1'b0;
            else if (clr_mask[i]) q <= 1'b0;
            else if (set_mask[i]) q <= 1'b1;
         end
         assign en_bits[i] = q;

         // R3
         set_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (set_mask[i] && !clr_mask[i]) |=> en_bits[i]);
         // R4
         clr_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
            clr_mask[i] |=> !en_bits[i]);
         // R5
         idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!set_mask[i] && !clr_mask[i]) |=> $stable(en_bits[i]));
      end
   end

endmodule

// File: rtl/pcg_rdport.sv
module pcg_rdport
   import pcg_pkg::*;
#(
   parameter int unsigned NUM_BANKS  = 2,
   parameter int unsigned BANK_W     = 32,
   parameter int unsigned BANK_SEL_W = 1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          rd_en,
   input  pcg_reg_e                      kind,
   input  logic [BANK_SEL_W-1:0]         bank_sel,
   input  logic [NUM_BANKS*BANK_W-1:0]   en_flat,
   output logic [BANK_W-1:0]             rdata
);

   logic [BANK_W-1:0] sel_word;

   always_comb begin
      sel_word = '0;
      for (int b = 0; b < NUM_BANKS; b++) begin
         if (bank_sel == BANK_SEL_W'(b)) sel_word = en_flat[b*BANK_W +: BANK_W];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         rdata <= '0;
      else if (rd_en && kind == REG_STAT) rdata <= sel_word;
      else                                rdata <= '0;
   end

   // R7
   nonstat_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && kind != REG_STAT) |=> rdata == '0);

endmodule

// File: rtl/pcg_ctrl.sv
module pcg_ctrl
   import pcg_pkg::*;
#(
   parameter int unsigned NUM_PERIPH = 64,
   parameter int unsigned NUM_FIXED  = 2,
   parameter int unsigned ADDR_W     = 8,
   parameter int unsigned DATA_W     = 32
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [ADDR_W-1:0]     bus_addr,
   input  logic                  bus_wr,
   input  logic [DATA_W-1:0]     bus_wdata,
   input  logic                  bus_rd,
   output logic [DATA_W-1:0]     bus_rdata,
   output logic [NUM_PERIPH-1:0] clk_en
);

   localparam int unsigned BANK_W     = PCG_BANK_W;
   localparam int unsigned NUM_BANKS  = (NUM_PERIPH + BANK_W - 1) / BANK_W;
   localparam int unsigned BANK_SEL_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
   localparam int unsigned FLAT_W     = NUM_BANKS * BANK_W;

   if (NUM_PERIPH > PCG_MAX_IDS) begin : g_chk_max
      $error("NUM_PERIPH exceeds supported maximum");
   end
   if (NUM_PERIPH <= NUM_FIXED) begin : g_chk_fixed
      $error("NUM_PERIPH must exceed NUM_FIXED");
   end
   if (DATA_W != BANK_W) begin : g_chk_data
      $error("DATA_W must equal bank width");
   end
   if (ADDR_W < 4 + BANK_SEL_W) begin : g_chk_addr
      $error("ADDR_W too small for bank count");
   end

   pcg_reg_e              kind;
   logic [BANK_SEL_W-1:0] bank_sel;
   logic [FLAT_W-1:0]     en_flat;

   pcg_decode #(
      .ADDR_W    (ADDR_W),
      .NUM_BANKS (NUM_BANKS),
      .BANK_SEL_W(BANK_SEL_W)
   ) u_decode (
      .addr    (bus_addr),
      .kind    (kind),
      .bank_sel(bank_sel)
   );

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic              hit;
      logic [BANK_W-1:0] set_mask;
      logic [BANK_W-1:0] clr_mask;

      assign hit      = bus_wr && (bank_sel == BANK_SEL_W'(b));
      assign set_mask = (hit && kind == REG_SET) ? bus_wdata : '0;
      assign clr_mask = (hit && kind == REG_CLR) ? bus_wdata : '0;

      pcg_bank #(
         .BANK_IDX  (b),
         .BANK_W    (BANK_W),
         .NUM_PERIPH(NUM_PERIPH),
         .NUM_FIXED (NUM_FIXED)
      ) u_bank (
         .clk     (clk),
         .rst_n   (rst_n),
         .set_mask(set_mask),
         .clr_mask(clr_mask),
         .en_bits (en_flat[b*BANK_W +: BANK_W])
      );
   end

   pcg_rdport #(
      .NUM_BANKS (NUM_BANKS),
      .BANK_W    (BANK_W),
      .BANK_SEL_W(BANK_SEL_W)
   ) u_rdport (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_en   (bus_rd),
      .kind    (kind),
      .bank_sel(bank_sel),
      .en_flat (en_flat),
      .rdata   (bus_rdata)
   );

   assign clk_en = en_flat[NUM_PERIPH-1:0];

   // R2
   fixed_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && kind == REG_STAT && bank_sel == '0) |=> bus_rdata[NUM_FIXED-1:0] == '1);
   // R8
   inert_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && (kind == REG_STAT || kind == REG_NONE)) |=> $stable(clk_en));

endmodule

// File: tb/tb_pcg_ctrl.sv
module tb_pcg_ctrl;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic        bus_rd = 1'b0;
   logic [31:0] bus_rdata;
   logic [63:0] clk_en;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [63:0] mirror = 64'h3;
   logic [31:0] exp_q[$];
   string       req_q[$];
   logic        rd_q = 1'b0;

   always #10 clk = ~clk;

   pcg_ctrl dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .clk_en(clk_en)
   );

   task automatic check64(string req, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic void model_write(logic [7:0] a, logic [31:0] d);
      if (a[7:5] == 3'b0 && a[1:0] == 2'b0) begin
         if (a[3:2] == 2'd0) mirror[a[4]*32 +: 32] = mirror[a[4]*32 +: 32] | d;
         if (a[3:2] == 2'd1) mirror[a[4]*32 +: 32] = mirror[a[4]*32 +: 32] & ~d;
      end
      mirror[1:0] = 2'b11;
   endfunction

   function automatic logic [31:0] model_read(logic [7:0] a);
      if (a[7:5] == 3'b0 && a[3:0] == 4'h8) return mirror[a[4]*32 +: 32];
      return 32'h0;
   endfunction

   task automatic bus_write(logic [7:0] a, logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
      model_write(a, d);
   endtask

   task automatic bus_read(string req, logic [7:0] a);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      exp_q.push_back(model_read(a));
      req_q.push_back(req);
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic check_en(string req);
      @(negedge clk);
      check64(req, clk_en, mirror);
   endtask

   always @(posedge clk) rd_q <= bus_rd;

   always @(negedge clk) begin
      if (rd_q && exp_q.size() > 0) begin
         logic [31:0] e;
         string r;
         e = exp_q.pop_front();
         r = req_q.pop_front();
         check64(r, {32'h0, bus_rdata}, {32'h0, e});
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      check_en("R1 reset enables");
      bus_read("R1 R6 bank0 status after reset", 8'h08);
      bus_read("R1 R6 bank1 status after reset", 8'h18);

      bus_write(8'h00, 32'hFFFF_FFFF);
      check_en("R3 R9 bank0 set all");
      bus_read("R6 bank0 status all set", 8'h08);
      bus_read("R9 bank1 status untouched", 8'h18);

      bus_write(8'h04, 32'h0000_0003);
      check_en("R2 clear of fixed ids ignored");
      bus_read("R2 bank0 status fixed bits", 8'h08);

      bus_write(8'h04, 32'h0000_F0F0);
      check_en("R4 R5 partial clear");

      bus_write(8'h10, 32'h8000_0001);
      check_en("R3 R9 bank1 ids 32 and 63");
      bus_read("R6 bank1 status", 8'h18);

      bus_write(8'h14, 32'h0000_0001);
      check_en("R4 bank1 clear id 32");

      bus_write(8'h08, 32'hFFFF_FFFF);
      check_en("R8 write to status ignored");
      bus_write(8'h20, 32'hFFFF_FFFF);
      check_en("R8 unmapped write ignored");
      bus_write(8'h02, 32'hFFFF_FFFF);
      check_en("R8 misaligned write ignored");
      bus_write(8'h0C, 32'hFFFF_FFFF);
      check_en("R8 unused offset write ignored");

      bus_read("R7 set reg reads zero", 8'h00);
      bus_read("R7 clear reg reads zero", 8'h04);
      bus_read("R7 bank1 clear reg reads zero", 8'h14);
      bus_read("R7 unmapped reads zero", 8'h38);

      bus_write(8'h04, 32'hFFFF_FFFF);
      bus_write(8'h14, 32'hFFFF_FFFF);
      check_en("R2 R4 clear everything");
      for (int k = 0; k < 64; k += 7) begin
         bus_write(k < 32 ? 8'h00 : 8'h10, 32'h1 << (k % 32));
         check_en("R3 R5 walking set");
      end
      bus_read("R6 bank0 walking status", 8'h08);
      bus_read("R6 bank1 walking status", 8'h18);

      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule